// File: doc/BRIEF.md
# Two-Wire Serial Memory Target with Write Lock

This block is an I2C target that behaves like a byte-wide serial memory with a 15-bit word address. It runs in the system clock domain and oversamples the SCL and SDA lines. SDA is driven through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. The upper five bits of the target address are fixed at `10101`. Two strap pins supply the two low bits, so four of these targets can share one bus.

A write transfer carries the device address, then two word-address bytes, then data bytes. The data bytes go into a page buffer and reach the storage array only when the bus master ends the transfer with STOP. A commit walks the whole page buffer and then holds the target busy for a programmable number of cycles. While the target is busy it does not answer its address. Reads return one byte per address and step the word pointer forward. A write-lock pin keeps the array from changing.

The storage depth is set by a parameter. The word pointer is always 15 bits wide. When the storage is smaller than 32 KiB, the upper pointer bits select aliases of the same cells. Set `STORE_AW` to 15 to get the full 32,768 bytes.

Top module: `serial_mem_target`

## Requirements
- R1: After reset, `sda_oe` and `busy` are both low.
- R2: The target ACKs a device address only when the seven address bits equal `{5'b10101, strap[1:0]}`, which gives 0x54 to 0x57. For any other address it never pulls SDA low. An ACK is SDA held low during the ninth clock of a byte.
- R3: In a write transfer, the target ACKs two word-address bytes, high byte first. Bit 7 of the high byte is ignored. A read that starts with a repeated START after this address phase begins at the loaded word address.
- R4: Each byte read returns the cell at the word pointer, and the pointer then advances by one. The pointer wraps from 0x7FFF to 0x0000. A read that sends no word address starts from where the pointer was left.
- R5: The target ACKs each write data byte and buffers it at the pointer's offset within a 64-byte page. The offset wraps from 63 to 0 inside the same page, so bytes never land in the next page.
- R6: Buffered bytes are written to storage only when STOP ends the transfer. A START or repeated START that comes before the STOP discards the buffered bytes.
- R7: While `wp` is high, the target still ACKs the device and word-address bytes but NACKs data bytes and buffers none of them. If `wp` is high when STOP arrives, the target discards the buffer and commits nothing.
- R8: After a STOP that commits data, `busy` stays high for exactly 64 + `WRITE_CYCLES` clock cycles. While `busy` is high, the target NACKs its own address.
- R9: The target releases SDA (`sda_oe` low) on the cycle after it detects a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pulls SDA low when high (open-drain enable) |
| strap | input | 2 | Selects the two low device-address bits |
| wp | input | 1 | Write lock; high blocks all changes to storage |
| busy | output | 1 | High while a page commit and its settle time run |

## Verification
The hardest cases to reach from the ports are those where buffered data must disappear without ever touching storage. One is a repeated START after data bytes have been accepted. The other is the lock pin rising between the last ACKed data byte and the STOP. The bench drives both sequences at bit level. It then reads back the affected cells, and also the cells the pointer moved on to, and compares them with values written earlier. The bench sets a long settle time so that a device address can be sent while `busy` is high and its NACK observed. An independent monitor times every `busy` pulse.

// File: rtl/smt_pkg.sv
`timescale 1ns/1ps
package smt_pkg;

  localparam logic [4:0] DEV_PREFIX = 5'b10101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } bus_state_e;

endpackage

// File: rtl/smt_line_mon.sv
`timescale 1ns/1ps
module smt_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smt_mem_array.sv
`timescale 1ns/1ps
module smt_mem_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // single write port and registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smt_page_buf.sv
`timescale 1ns/1ps
module smt_page_buf #(
  parameter int WORD_AW      = 15,
  parameter int PAGE_AW      = 6,
  parameter int WRITE_CYCLES = 200
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [PAGE_AW-1:0]         wr_off,
  input  logic [7:0]                 wr_data,
  input  logic [WORD_AW-PAGE_AW-1:0] wr_page,
  input  logic                       discard,
  input  logic                       commit_req,
  output logic                       mem_we,
  output logic [WORD_AW-1:0]         mem_waddr,
  output logic [7:0]                 mem_wdata,
  output logic                       busy
);
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int PN_W  = WORD_AW - PAGE_AW;
  localparam int TOTAL = PAGE + WRITE_CYCLES;
  localparam int CNT_W = $clog2(TOTAL);

  logic [7:0]         pbuf [PAGE];
  logic [PAGE-1:0]    valid;
  logic [PN_W-1:0]    page_q;
  logic               walking;
  logic [PAGE_AW-1:0] idx;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (wr_en && !busy) pbuf[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= '0;
      page_q    <= '0;
      walking   <= 1'b0;
      idx       <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (wr_en && !busy) begin
        valid[wr_off] <= 1'b1;
        page_q        <= wr_page;
      end
      if (busy) begin
        if (walking) begin
          mem_we     <= valid[idx];
          mem_waddr  <= {page_q, idx};
          mem_wdata  <= pbuf[idx];
          valid[idx] <= 1'b0;
          idx        <= idx + 1'b1;
          if (idx == PAGE_AW'(PAGE - 1)) walking <= 1'b0;
        end
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end else if (commit_req && (|valid)) begin
        busy    <= 1'b1;
        walking <= 1'b1;
        idx     <= '0;
        cnt     <= CNT_W'(TOTAL - 1);
      end else if (discard) begin
        valid <= '0;
      end
    end
  end
endmodule

// File: rtl/smt_bus_fsm.sv
`timescale 1ns/1ps
module smt_bus_fsm
  import smt_pkg::*;
#(
  parameter int WORD_AW = 15,
  parameter int PAGE_AW = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       start_det,
  input  logic                       stop_det,
  input  logic                       sda_s,
  input  logic [1:0]                 strap,
  input  logic                       wp,
  input  logic                       busy,
  input  logic [7:0]                 rd_data,
  output logic                       sda_oe,
  output logic [WORD_AW-1:0]         ptr,
  output logic                       buf_we,
  output logic [PAGE_AW-1:0]         buf_off,
  output logic [7:0]                 buf_data,
  output logic [WORD_AW-PAGE_AW-1:0] buf_page
);
  bus_state_e state, nxt;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       rx_state;

  assign rx_state = (state == ST_DEV) || (state == ST_AHI) ||
                    (state == ST_ALO) || (state == ST_WDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      buf_we   <= 1'b0;
      buf_off  <= '0;
      buf_data <= '0;
      buf_page <= '0;
    end else begin
      buf_we <= 1'b0;
      if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && bitcnt == 4'd8) begin
          bitcnt <= '0;
          case (state)
            ST_DEV: begin
              if (shreg[7:1] == {DEV_PREFIX, strap} && !busy) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                nxt    <= shreg[0] ? ST_RDATA : ST_AHI;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_AHI: begin
              ptr[WORD_AW-1:8] <= shreg[WORD_AW-9:0];
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              nxt    <= ST_ALO;
            end
            ST_ALO: begin
              ptr[7:0] <= shreg;
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              nxt    <= ST_WDATA;
            end
            default: begin
              state <= ST_ACK;
              nxt   <= ST_WDATA;
              if (!wp) begin
                sda_oe   <= 1'b1;
                buf_we   <= 1'b1;
                buf_off  <= ptr[PAGE_AW-1:0];
                buf_data <= shreg;
                buf_page <= ptr[WORD_AW-1:PAGE_AW];
                ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
              end
            end
          endcase
        end
      end else begin
        case (state)
          ST_ACK: begin
            if (scl_fall) begin
              state  <= nxt;
              bitcnt <= '0;
              sda_oe <= (nxt == ST_RDATA) ? ~rd_data[7] : 1'b0;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~rd_data[3'd7 - bitcnt[2:0]];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              state  <= sda_s ? ST_SKIP : ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_mem_target.sv
`timescale 1ns/1ps
module serial_mem_target #(
  parameter int WORD_AW      = 15,
  parameter int STORE_AW     = 11,
  parameter int PAGE_AW      = 6,
  parameter int WRITE_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap,
  input  logic       wp,
  output logic       busy
);
  localparam int PN_W = WORD_AW - PAGE_AW;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [WORD_AW-1:0] ptr;
  logic               buf_we;
  logic [PAGE_AW-1:0] buf_off;
  logic [7:0]         buf_data;
  logic [PN_W-1:0]    buf_page;
  logic               mem_we;
  logic [WORD_AW-1:0] mem_waddr;
  logic [7:0]         mem_wdata;
  logic [7:0]         rd_data;
  logic               commit_req, discard;

  assign commit_req = stop_det & ~wp;
  assign discard    = start_det | (stop_det & wp);

  smt_line_mon #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smt_bus_fsm #(.WORD_AW(WORD_AW), .PAGE_AW(PAGE_AW)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .strap(strap), .wp(wp), .busy(busy), .rd_data(rd_data),
    .sda_oe(sda_oe), .ptr(ptr), .buf_we(buf_we), .buf_off(buf_off),
    .buf_data(buf_data), .buf_page(buf_page)
  );

  smt_page_buf #(.WORD_AW(WORD_AW), .PAGE_AW(PAGE_AW), .WRITE_CYCLES(WRITE_CYCLES)) u_pbuf (
    .clk(clk), .rst(rst), .wr_en(buf_we), .wr_off(buf_off),
    .wr_data(buf_data), .wr_page(buf_page), .discard(discard),
    .commit_req(commit_req), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  smt_mem_array #(.AW(STORE_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr[STORE_AW-1:0]),
    .wdata(mem_wdata), .raddr(ptr[STORE_AW-1:0]), .rdata(rd_data)
  );

  // pointer bits above the storage depth select aliases of the same cells
  generate
    if (STORE_AW < WORD_AW) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^{ptr[WORD_AW-1:STORE_AW], mem_waddr[WORD_AW-1:STORE_AW]};
    end
  endgenerate
endmodule

// File: rtl/smt_checker.sv
`timescale 1ns/1ps
module smt_checker (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic busy,
  input logic wp,
  input logic start_det,
  input logic stop_det,
  input logic buf_we,
  input logic mem_we
);
  assert_release_on_start_R9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_lock_blocks_buffer_R7: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !$past(wp));

  assert_commit_follows_stop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(stop_det) && !$past(wp)));

  assert_store_only_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_no_buffering_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !busy);
endmodule

bind serial_mem_target smt_checker u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .busy(busy), .wp(wp),
  .start_det(start_det), .stop_det(stop_det), .buf_we(buf_we), .mem_we(mem_we)
);

// File: tb/test_serial_mem_target.sv
`timescale 1ns/1ps
module test_serial_mem_target;
  localparam int WR_CYC = 1000;
  localparam int TOTAL  = 64 + WR_CYC;
  localparam int Q      = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic wp = 1'b0;
  logic sda_oe, busy, sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  serial_mem_target #(.WORD_AW(15), .STORE_AW(11), .PAGE_AW(6),
                      .WRITE_CYCLES(WR_CYC), .SYNC_STAGES(2)) i_serial_mem_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .wp(wp), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [7:0] v; string req; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] act_q[$];
  logic [7:0] bq[$];
  exp_t       m_e;
  logic [7:0] m_a;

  always @(negedge clk) begin
    if (act_q.size() != 0) begin
      m_a = act_q.pop_front();
      if (exp_q.size() == 0) chk("scoreboard", int'(m_a), -1);
      else begin
        m_e = exp_q.pop_front();
        chk(m_e.req, int'(m_a), int'(m_e.v));
      end
    end
  end

  // busy pulse length monitor (R8)
  int busy_run = 0;
  always @(negedge clk) begin
    if (rst) busy_run = 0;
    else if (busy) busy_run++;
    else if (busy_run != 0) begin
      chk("R8 busy length", busy_run, TOTAL);
      busy_run = 0;
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic put_bit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); scl_m = 0; wq(); endtask
  task automatic get_bit(output logic b);
    sda_m = 1; wq(); scl_m = 1; wq(); b = sda_line; scl_m = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(last);
  endtask

  task automatic dev(input logic [6:0] a, input logic rd, input logic exp_ack, input string req);
    logic ack;
    bus_start();
    send_byte({a, rd}, ack);
    chk(req, int'(ack), int'(exp_ack));
  endtask

  task automatic word_addr(input logic [15:0] a);
    logic ack;
    send_byte(a[15:8], ack); chk("R3 high address ACK", int'(ack), 1);
    send_byte(a[7:0], ack);  chk("R3 low address ACK", int'(ack), 1);
  endtask

  task automatic send_data(input logic exp_ack, input string req);
    logic ack;
    foreach (bq[i]) begin
      send_byte(bq[i], ack);
      chk(req, int'(ack), int'(exp_ack));
    end
    bq.delete();
  endtask

  task automatic read_bytes(input string req);
    logic [7:0] d;
    for (int i = 0; i < bq.size(); i++) begin
      exp_q.push_back('{bq[i], req});
      recv_byte(i == bq.size() - 1, d);
      act_q.push_back(d);
    end
    bq.delete();
  endtask

  task automatic write_mem(input logic [15:0] a);
    dev(7'h56, 1'b0, 1'b1, "R2 device ACK");
    word_addr(a);
    send_data(1'b1, "R5 data ACK");
    bus_stop();
  endtask

  task automatic read_mem(input logic [15:0] a, input string req);
    dev(7'h56, 1'b0, 1'b1, "R2 device ACK");
    word_addr(a);
    dev(7'h56, 1'b1, 1'b1, "R3 read after repeated START");
    read_bytes(req);
    bus_stop();
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic stage(input logic [7:0] v); bq.push_back(v); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 busy after reset", int'(busy), 0);

    // R2: address decode with strap = 10 -> 0x56
    dev(7'h54, 1'b0, 1'b0, "R2 wrong address 0x54 NACK"); bus_stop();
    dev(7'h57, 1'b0, 1'b0, "R2 wrong address 0x57 NACK"); bus_stop();
    dev(7'h56, 1'b0, 1'b1, "R2 own address 0x56 ACK");    bus_stop();
    strap = 2'b01;
    dev(7'h55, 1'b0, 1'b1, "R2 strap 01 address 0x55 ACK"); bus_stop();
    dev(7'h56, 1'b0, 1'b0, "R2 strap 01 address 0x56 NACK"); bus_stop();
    strap = 2'b10;

    // R5/R6/R8: page write, then address attempt while busy
    for (int i = 0; i < 8; i++) stage(8'h10 + 8'(i));
    write_mem(16'h0100);
    chk("R8 busy after commit STOP", int'(busy), 1);
    dev(7'h56, 1'b0, 1'b0, "R8 address NACK while busy"); bus_stop();
    wait_idle();
    for (int i = 0; i < 8; i++) stage(8'h10 + 8'(i));
    read_mem(16'h0100, "R4 sequential read");

    stage(8'h5A); write_mem(16'h0140); wait_idle();

    // R5: wrap inside the page 0x0100..0x013F
    stage(8'hA0); stage(8'hA1); stage(8'hA2); stage(8'hA3);
    write_mem(16'h013E); wait_idle();
    stage(8'hA0); stage(8'hA1); read_mem(16'h013E, "R5 tail of page");
    stage(8'hA2); read_mem(16'h0100, "R5 wrapped into page start");
    // R4: current-address read continues at 0x0101
    dev(7'h56, 1'b1, 1'b1, "R4 current read device ACK");
    stage(8'hA3); stage(8'h12); read_bytes("R4 current-address read");
    bus_stop();
    chk("R9 sda released after STOP", int'(sda_oe), 0);
    stage(8'h5A); read_mem(16'h0140, "R5 next page untouched");

    // R7: write lock
    wp = 1;
    dev(7'h56, 1'b0, 1'b1, "R7 device ACK while locked");
    word_addr(16'h0100);
    stage(8'hEE); send_data(1'b0, "R7 data NACK while locked");
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R7 no commit while locked", int'(busy), 0);
    wp = 0;
    stage(8'hA2); read_mem(16'h0100, "R7 cell unchanged");

    // R7: lock raised before STOP discards buffer
    dev(7'h56, 1'b0, 1'b1, "R2 device ACK");
    word_addr(16'h0102);
    stage(8'h77); send_data(1'b1, "R5 data ACK");
    wp = 1;
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R7 lock at STOP blocks commit", int'(busy), 0);
    wp = 0;
    stage(8'h12); read_mem(16'h0102, "R7 cell unchanged after late lock");

    // R6: repeated START discards buffered data, read starts at advanced pointer
    dev(7'h56, 1'b0, 1'b1, "R2 device ACK");
    word_addr(16'h0103);
    stage(8'h99); stage(8'h98); send_data(1'b1, "R5 data ACK");
    dev(7'h56, 1'b1, 1'b1, "R6 read after repeated START");
    stage(8'h15); stage(8'h16); read_bytes("R6 read continues at pointer");
    bus_stop();
    repeat (8) @(negedge clk);
    chk("R6 no commit after discard", int'(busy), 0);
    stage(8'h13); read_mem(16'h0103, "R6 discarded bytes not stored");

    // R4: pointer rollover; R3: bit 15 ignored
    stage(8'hC3); write_mem(16'h7FFF); wait_idle();
    stage(8'h3C); write_mem(16'h0000); wait_idle();
    stage(8'hC3); stage(8'h3C); read_mem(16'h7FFF, "R4 rollover 7FFF to 0000");
    stage(8'hC3); read_mem(16'hFFFF, "R3 top address bit ignored");

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard leftover", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule